// File: doc/BRIEF.md
# Page History Bit Update Controller

This block sits beside an address-translation unit and decides, for every memory access, whether the page-table entry in memory must be rewritten to record that the page was referenced (R) or changed (C). Each access arrives with its type (read or write, hint touch or normal), the instruction- and data-translation enable flags, the way it was translated (page TLB hit, page TLB miss, block translation, or direct-store segment) and the R/C bits cached in the hitting TLB entry.

When an update is needed, the controller raises a table-search request toward the page-table walker and holds it until the walker acknowledges. After a write hit, it also tells the TLB to set its own copy of C. A done pulse closes every accepted access and carries an outcome code. Accesses enter over a valid/ready handshake. `acc_ready` is low while a table search is outstanding. An access presented with `acc_valid` high and `acc_ready` low is not taken, and its fields must be held until a cycle in which `acc_ready` is high. The walker side uses a request/acknowledge pair: the request stays up with stable fields until `walk_ack` is sampled high.

Top module: `phb_ctrl`

## Requirements
- R1: An access whose path is block translation (`acc_path`=2) or direct-store segment (`acc_path`=3) never raises `walk_req_valid` and completes with `done_code`=0 (no action).
- R2: When the enable flag selected by `acc_fetch` (`xlat_i_en` for fetches, `xlat_d_en` otherwise) is 0, the access completes with `done_code`=0 and no table search, whatever its path and R/C bits.
- R3: A TLB hit (`acc_path`=0) with `tlb_r`=1, `tlb_c`=0 completes with code 0 for a read or a touch. For a non-touch write it raises a table search with `walk_req_set_c`=1 and `walk_req_addr` equal to the access address.
- R4: A TLB hit with `tlb_r`=1, `tlb_c`=1 completes with code 0 for reads and writes.
- R5: A TLB hit with `tlb_r`=0 (R/C 00 or 01) pulses `rc_err` together with `done`, reports `done_code`=3, and starts no table search.
- R6: A non-touch TLB miss (`acc_path`=1) with translation enabled raises a table search, with `walk_req_set_c` equal to `acc_write`. Its acknowledge never pulses `tlb_setc_valid`.
- R7: A touch access that misses the TLB with translation enabled completes with `done_code`=2 (discarded) and starts no table search.
- R8: In the cycle in which a write-hit search is acknowledged, `tlb_setc_valid` is high and `tlb_setc_idx` equals the index of the entry that hit.
- R9: At most one table search is outstanding. `acc_ready` is low from the cycle after a search starts until the cycle after its acknowledge, and an access held during that time is not consumed.
- R10: `done` pulses for exactly one cycle per accepted access. That cycle is the one after acceptance when no search is needed, and the one after the acknowledge otherwise. Searched accesses report `done_code`=1.
- R11: While `walk_ack` is low, `walk_req_valid`, `walk_req_addr` and `walk_req_set_c` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| acc_valid | input | 1 | Access offered |
| acc_ready | output | 1 | Access can be taken this cycle |
| acc_write | input | 1 | 1 = write (store), 0 = read |
| acc_touch | input | 1 | 1 = hint touch access |
| acc_fetch | input | 1 | 1 = instruction fetch, selects the instruction enable flag |
| xlat_i_en | input | 1 | Instruction translation enabled |
| xlat_d_en | input | 1 | Data translation enabled |
| acc_path | input | 2 | 0 TLB hit, 1 TLB miss, 2 block hit, 3 direct-store |
| tlb_r | input | 1 | R bit of the hitting TLB entry |
| tlb_c | input | 1 | C bit of the hitting TLB entry |
| tlb_idx | input | IW | Index of the hitting TLB entry |
| acc_addr | input | AW | Access address |
| walk_req_valid | output | 1 | Table-search request |
| walk_req_addr | output | AW | Address whose entry must be updated |
| walk_req_set_c | output | 1 | Search must also set C |
| walk_ack | input | 1 | Walker finished the request |
| tlb_setc_valid | output | 1 | Set C in the TLB entry this cycle |
| tlb_setc_idx | output | IW | TLB entry to mark changed |
| done | output | 1 | Access finished, one cycle |
| done_code | output | 2 | 0 no action, 1 searched, 2 discarded touch, 3 R/C fault |
| rc_err | output | 1 | Invalid R/C pair seen on a hit |

## Verification
The hardest situation to reach from the ports is a second access arriving while a search is still waiting. It must sit unconsumed behind a low `acc_ready` and must not produce a done pulse. The stimulus reaches this by giving the walker a random acknowledge delay and, during that wait, driving `acc_valid` high with a random access. The bench then checks that no done appears and that the request fields do not move. Random accesses are weighted toward TLB hits and misses with translation enabled, so that write hits on clean entries and touch misses come up often. Directed cases cover each invalid R/C pair and real-addressing mode.

// File: rtl/phb_pkg.sv
package phb_pkg;
  typedef enum logic [1:0] {
    PATH_TLB_HIT  = 2'd0,
    PATH_TLB_MISS = 2'd1,
    PATH_BLOCK    = 2'd2,
    PATH_DSTORE   = 2'd3
  } path_e;

  typedef enum logic [1:0] {
    OUT_PASS  = 2'd0,
    OUT_WALK  = 2'd1,
    OUT_NOOP  = 2'd2,
    OUT_RCERR = 2'd3
  } outcome_e;

  typedef struct packed {
    outcome_e outcome;
    logic     set_c;
    logic     upd_tlb;
  } verdict_t;
endpackage

// File: rtl/phb_classify.sv
module phb_classify
  import phb_pkg::*;
(
  input  logic       write,
  input  logic       touch,
  input  logic       fetch,
  input  logic       ixlat_en,
  input  logic       dxlat_en,
  input  logic [1:0] path,
  input  logic       r_bit,
  input  logic       c_bit,
  output verdict_t   verdict
);
  logic  xlat_on;
  path_e path_t;

  assign xlat_on = fetch ? ixlat_en : dxlat_en;
  assign path_t  = path_e'(path);

  always_comb begin
    verdict = '{outcome: OUT_PASS, set_c: 1'b0, upd_tlb: 1'b0};
    if (xlat_on) begin
      unique case (path_t)
        PATH_TLB_HIT: begin
          if (!r_bit) begin
            verdict.outcome = OUT_RCERR;
          end else if (!c_bit && write && !touch) begin
            verdict.outcome = OUT_WALK;
            verdict.set_c   = 1'b1;
            verdict.upd_tlb = 1'b1;
          end
        end
        PATH_TLB_MISS: begin
          if (touch) begin
            verdict.outcome = OUT_NOOP;
          end else begin
            verdict.outcome = OUT_WALK;
            verdict.set_c   = write;
          end
        end
        default: verdict.outcome = OUT_PASS;
      endcase
    end
  end
endmodule

// File: rtl/phb_walk_seq.sv
module phb_walk_seq
  import phb_pkg::*;
#(
  parameter int AW = 32,
  parameter int IW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          start_set_c,
  input  logic          start_upd_tlb,
  input  logic [AW-1:0] start_addr,
  input  logic [IW-1:0] start_idx,
  input  logic          walk_ack,
  output logic          busy,
  output logic          walk_req_valid,
  output logic [AW-1:0] walk_req_addr,
  output logic          walk_req_set_c,
  output logic          tlb_setc_valid,
  output logic [IW-1:0] tlb_setc_idx,
  output logic          finish
);
  typedef enum logic {ST_IDLE, ST_WAIT} st_e;
  st_e           st_q;
  logic [AW-1:0] addr_q;
  logic [IW-1:0] idx_q;
  logic          setc_q;
  logic          upd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      addr_q <= '0;
      idx_q  <= '0;
      setc_q <= 1'b0;
      upd_q  <= 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (start) begin
          st_q   <= ST_WAIT;
          addr_q <= start_addr;
          idx_q  <= start_idx;
          setc_q <= start_set_c;
          upd_q  <= start_upd_tlb;
        end
        ST_WAIT: if (walk_ack) st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign busy           = (st_q == ST_WAIT);
  assign walk_req_valid = busy;
  assign walk_req_addr  = addr_q;
  assign walk_req_set_c = setc_q;
  assign finish         = busy && walk_ack;
  assign tlb_setc_valid = finish && upd_q;
  assign tlb_setc_idx   = idx_q;

  assert_req_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (walk_req_valid && !walk_ack) |=> (walk_req_valid && $stable(walk_req_addr)
                                       && $stable(walk_req_set_c)));

  assert_setc_ack_R8: assert property (@(posedge clk) disable iff (!rst_n)
    tlb_setc_valid |-> (walk_ack && walk_req_valid && walk_req_set_c));

  assert_req_drop_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (walk_req_valid && walk_ack) |=> !walk_req_valid);
endmodule

// File: rtl/phb_ctrl.sv
module phb_ctrl
  import phb_pkg::*;
#(
  parameter int AW = 32,
  parameter int IW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          acc_valid,
  output logic          acc_ready,
  input  logic          acc_write,
  input  logic          acc_touch,
  input  logic          acc_fetch,
  input  logic          xlat_i_en,
  input  logic          xlat_d_en,
  input  logic [1:0]    acc_path,
  input  logic          tlb_r,
  input  logic          tlb_c,
  input  logic [IW-1:0] tlb_idx,
  input  logic [AW-1:0] acc_addr,
  output logic          walk_req_valid,
  output logic [AW-1:0] walk_req_addr,
  output logic          walk_req_set_c,
  input  logic          walk_ack,
  output logic          tlb_setc_valid,
  output logic [IW-1:0] tlb_setc_idx,
  output logic          done,
  output logic [1:0]    done_code,
  output logic          rc_err
);
  verdict_t verdict;
  logic     busy;
  logic     accept;
  logic     finish;
  logic     quick;

  phb_classify u_classify (
    .write    (acc_write),
    .touch    (acc_touch),
    .fetch    (acc_fetch),
    .ixlat_en (xlat_i_en),
    .dxlat_en (xlat_d_en),
    .path     (acc_path),
    .r_bit    (tlb_r),
    .c_bit    (tlb_c),
    .verdict  (verdict)
  );

  assign acc_ready = !busy;
  assign accept    = acc_valid && acc_ready;
  assign quick     = accept && (verdict.outcome != OUT_WALK);

  phb_walk_seq #(.AW(AW), .IW(IW)) u_walk (
    .clk            (clk),
    .rst_n          (rst_n),
    .start          (accept && (verdict.outcome == OUT_WALK)),
    .start_set_c    (verdict.set_c),
    .start_upd_tlb  (verdict.upd_tlb),
    .start_addr     (acc_addr),
    .start_idx      (tlb_idx),
    .walk_ack       (walk_ack),
    .busy           (busy),
    .walk_req_valid (walk_req_valid),
    .walk_req_addr  (walk_req_addr),
    .walk_req_set_c (walk_req_set_c),
    .tlb_setc_valid (tlb_setc_valid),
    .tlb_setc_idx   (tlb_setc_idx),
    .finish         (finish)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done      <= 1'b0;
      done_code <= 2'd0;
      rc_err    <= 1'b0;
    end else begin
      done      <= quick || finish;
      done_code <= finish ? OUT_WALK : (quick ? verdict.outcome : OUT_PASS);
      rc_err    <= quick && (verdict.outcome == OUT_RCERR);
    end
  end

  assert_one_walk_R9: assert property (@(posedge clk) disable iff (!rst_n)
    walk_req_valid |-> !acc_ready);

  assert_quick_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
    quick |=> done);

  assert_rcerr_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rc_err |-> (done && !walk_req_valid));

  assert_block_nowalk_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && acc_path[1]) |=> !walk_req_valid);
endmodule

// File: tb/tb_phb_ctrl.sv
module tb_phb_ctrl;
  localparam int AW = 32;
  localparam int IW = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic acc_valid = 0, acc_write = 0, acc_touch = 0, acc_fetch = 0;
  logic xlat_i_en = 0, xlat_d_en = 0, tlb_r = 0, tlb_c = 0, walk_ack = 0;
  logic [1:0] acc_path = 0;
  logic [IW-1:0] tlb_idx = 0;
  logic [AW-1:0] acc_addr = 0;
  logic acc_ready, walk_req_valid, walk_req_set_c, tlb_setc_valid, done, rc_err;
  logic [AW-1:0] walk_req_addr;
  logic [IW-1:0] tlb_setc_idx;
  logic [1:0] done_code;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  phb_ctrl #(.AW(AW), .IW(IW)) dut (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_ready(acc_ready),
    .acc_write(acc_write), .acc_touch(acc_touch), .acc_fetch(acc_fetch),
    .xlat_i_en(xlat_i_en), .xlat_d_en(xlat_d_en), .acc_path(acc_path),
    .tlb_r(tlb_r), .tlb_c(tlb_c), .tlb_idx(tlb_idx), .acc_addr(acc_addr),
    .walk_req_valid(walk_req_valid), .walk_req_addr(walk_req_addr),
    .walk_req_set_c(walk_req_set_c), .walk_ack(walk_ack),
    .tlb_setc_valid(tlb_setc_valid), .tlb_setc_idx(tlb_setc_idx),
    .done(done), .done_code(done_code), .rc_err(rc_err)
  );

  task automatic check(input bit ok, input string req,
                       input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Expected outcome: 0 none, 1 search, 2 discarded touch, 3 R/C fault
  function automatic int exp_code(bit wr, bit tch, bit fch, bit ie, bit de,
                                  int path, bit r, bit c);
    bit on;
    on = fch ? ie : de;
    if (!on) return 0;                          // R2
    if (path >= 2) return 0;                    // R1
    if (path == 1) return tch ? 2 : 1;          // R6 R7
    if (!r) return 3;                           // R5
    if (!c && wr && !tch) return 1;             // R3
    return 0;                                   // R3 R4
  endfunction

  task automatic run_one(input bit wr, input bit tch, input bit fch,
                         input bit ie, input bit de, input int path,
                         input bit r, input bit c, input int delay);
    int ec;
    bit hit_upd;
    logic [AW-1:0] a;
    logic [IW-1:0] ix;
    a  = $urandom;
    ix = IW'($urandom);
    ec = exp_code(wr, tch, fch, ie, de, path, r, c);
    hit_upd = (ec == 1) && (path == 0);
    @(negedge clk);
    check(acc_ready == 1'b1, "R9 idle ready", acc_ready, 1);
    acc_valid = 1; acc_write = wr; acc_touch = tch; acc_fetch = fch;
    xlat_i_en = ie; xlat_d_en = de; acc_path = 2'(path);
    tlb_r = r; tlb_c = c; tlb_idx = ix; acc_addr = a;
    @(negedge clk);
    acc_valid = 0;
    if (ec == 1) begin
      check(walk_req_valid == 1'b1, "R3/R6 search raised", walk_req_valid, 1);
      check(walk_req_addr == a, "R3 search addr", walk_req_addr, a);
      check(walk_req_set_c == (path == 0 ? 1'b1 : wr), "R6 set_c flag",
            walk_req_set_c, (path == 0) ? 1 : wr);
      check(done == 1'b0, "R10 no early done", done, 0);
      for (int k = 0; k < delay; k++) begin
        // Offer a competing access while busy; it must not be taken
        acc_valid = 1; acc_path = 2'd2; acc_addr = $urandom;
        @(negedge clk);
        check(acc_ready == 1'b0, "R9 busy stall", acc_ready, 0);
        check(done == 1'b0, "R9 held access not consumed", done, 0);
        check(walk_req_valid && walk_req_addr == a, "R11 request held",
              walk_req_addr, a);
      end
      acc_valid = 0;
      walk_ack = 1;
      #1;
      check(tlb_setc_valid == hit_upd, "R8 tlb setc pulse", tlb_setc_valid, hit_upd);
      if (hit_upd) check(tlb_setc_idx == ix, "R8 tlb setc idx", tlb_setc_idx, ix);
      @(negedge clk);
      walk_ack = 0;
      check(done == 1'b1 && done_code == 2'd1, "R10 done after ack",
            {done, done_code}, 3'b101);
      check(walk_req_valid == 1'b0, "R9 search released", walk_req_valid, 0);
    end else begin
      check(walk_req_valid == 1'b0, "R1/R2/R7 no search", walk_req_valid, 0);
      check(done == 1'b1, "R10 quick done", done, 1);
      check(done_code == 2'(ec), "R10 done code", done_code, ec);
      check(rc_err == (ec == 3), "R5 rc_err", rc_err, ec == 3);
    end
    @(negedge clk);
    check(done == 1'b0, "R10 single done", done, 0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=hang expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h1F2E3D4C));
    repeat (3) @(negedge clk);
    check(done == 0 && walk_req_valid == 0 && rc_err == 0 && tlb_setc_valid == 0,
          "R10 reset quiet", {done, walk_req_valid, rc_err}, 0);
    rst_n = 1;
    // Directed corners
    run_one(1, 0, 0, 1, 1, 2, 1, 0, 0);   // R1 block write
    run_one(1, 0, 0, 1, 1, 3, 1, 0, 0);   // R1 direct-store write
    run_one(1, 0, 0, 1, 0, 0, 1, 0, 0);   // R2 real mode write hit 10
    run_one(0, 1, 0, 0, 0, 1, 0, 0, 0);   // R2 real mode touch miss
    run_one(0, 0, 0, 1, 1, 0, 1, 0, 0);   // R3 read hit 10
    run_one(1, 0, 0, 1, 1, 0, 1, 0, 2);   // R3 R8 write hit 10
    run_one(1, 1, 0, 1, 1, 0, 1, 0, 0);   // R3 touch-for-store hit
    run_one(1, 0, 0, 1, 1, 0, 1, 1, 0);   // R4 write hit 11
    run_one(0, 0, 0, 1, 1, 0, 0, 0, 0);   // R5 pair 00
    run_one(1, 0, 0, 1, 1, 0, 0, 1, 0);   // R5 pair 01
    run_one(0, 0, 0, 1, 1, 1, 1, 1, 0);   // R6 read miss
    run_one(1, 0, 0, 1, 1, 1, 1, 1, 3);   // R6 write miss
    run_one(1, 1, 0, 1, 1, 1, 1, 1, 0);   // R7 touch miss
    run_one(0, 0, 1, 1, 0, 0, 1, 0, 0);   // R2 fetch uses instruction flag
    // Random mix
    for (int n = 0; n < 400; n++) begin
      int p;
      p = ($urandom % 8 < 6) ? int'($urandom % 2) : int'(2 + $urandom % 2);
      run_one($urandom % 2, ($urandom % 4) == 0, ($urandom % 4) == 0,
              ($urandom % 8) != 0, ($urandom % 8) != 0, p,
              ($urandom % 8) != 0, $urandom % 2, $urandom % 5);
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule